// File: doc/BRIEF.md
# Edge-Triggered Capture Unit

This block is the capture half of a timer. It watches a set of external capture pins and, when a pin makes a transition that its channel has been told to watch for, it copies the current timer count into that channel's capture register. It can also raise that channel's flag in the interrupt flag register. The timer count comes in as an input. This block neither generates the count nor compares it against anything.

Each channel has three control bits. One enables capture on a rising edge, one enables capture on a falling edge, and one makes a capture raise the flag. Setting both edge bits makes the channel capture on every transition. Software configures the block through a small register bus. The bus reaches the control word, the write-1-to-clear flag register and the read-only capture registers. The pins are asynchronous and pass through a two-stage synchroniser, so every capture lands a fixed number of clock cycles after the pin moves.

Top module: `edge_capture`

## Requirements
- R1: After reset, every capture register, every flag and the control word read as zero.
- R2: With control bit 3*i set, a 0-to-1 transition on pin i loads capture register i with the timer count.
- R3: With control bit 3*i+1 set, a 1-to-0 transition on pin i loads capture register i with the timer count.
- R4: With both edge bits of a channel set, every transition of its pin loads the register. A transition whose edge bit is clear leaves the register unchanged.
- R5: A pin change driven between clock edges is captured at the third rising clock edge after it. The register holds its old value through the second edge and takes the count present at the third.
- R6: When a channel's register is loaded and control bit 3*i+2 is set, flag i (bit i of address 1) becomes 1. With that bit clear, a load does not set the flag.
- R7: Writing address 1 clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R8: If a capture sets flag i in the same cycle that a write clears it, the flag ends up set.
- R9: Capture register i is read at address 2+i. Bus writes to these addresses have no effect.
- R10: A new capture overwrites the capture register even if the previous value was never read.
- R11: A write to address 0 sets the control word, and a read of address 0 returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_cnt | input | TW | Free-running timer count |
| cap_pin | input | NCH | Asynchronous capture pins |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register address |
| bus_wdata | input | TW | Register write data |
| bus_rdata | output | TW | Register read data (combinational) |
| cap_val | output | NCH*TW | All capture registers, channel i at bits [i*TW +: TW] |
| cap_flag | output | NCH | Capture interrupt flags |

## Verification
Suppose the synchroniser is too short or too long, or the edge polarity is decoded wrongly. Then a capture register takes a count from the wrong cycle, or takes one when it should not. Because the counter moves every cycle, this shows on cap_val at the third clock edge after the pin change. If the flag logic is wrong, cap_flag shows the error on the same edge as the load, or on the edge after a clearing write. Control-word or address decode errors appear at once as wrong bus_rdata.

// File: rtl/edge_capture.sv
module edge_capture #(
  parameter int NCH = 4,
  parameter int TW  = 32,
  parameter int AW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     tmr_cnt,
  input  logic [NCH-1:0]    cap_pin,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [TW-1:0]     bus_wdata,
  output logic [TW-1:0]     bus_rdata,
  output logic [NCH*TW-1:0] cap_val,
  output logic [NCH-1:0]    cap_flag
);
  localparam int CW = 3 * NCH;

  logic [NCH-1:0] sync1, sync2, prev;
  logic [CW-1:0]  ctrl;
  logic [NCH-1:0] rise_en, fall_en, irq_en, cap_ld, clr;
  logic [TW-1:0]  cap_r [NCH];

  assign clr = (bus_we && bus_addr == AW'(1)) ? bus_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= cap_pin;
      sync2 <= sync1;
      prev  <= sync2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl <= '0;
    else if (bus_we && bus_addr == AW'(0)) ctrl <= bus_wdata[CW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cap_flag <= '0;
    else cap_flag <= (cap_flag & ~clr) | (cap_ld & irq_en);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign rise_en[i] = ctrl[3*i];
    assign fall_en[i] = ctrl[3*i+1];
    assign irq_en[i]  = ctrl[3*i+2];
    assign cap_ld[i]  = (rise_en[i] &  sync2[i] & ~prev[i]) |
                        (fall_en[i] & ~sync2[i] &  prev[i]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cap_r[i] <= '0;
      else if (cap_ld[i]) cap_r[i] <= tmr_cnt;

    assign cap_val[i*TW +: TW] = cap_r[i];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(0)) bus_rdata[CW-1:0] = ctrl;
    else if (bus_addr == AW'(1)) bus_rdata[NCH-1:0] = cap_flag;
    for (int i = 0; i < NCH; i++)
      if (bus_addr == AW'(i + 2)) bus_rdata = cap_r[i];
  end
endmodule

// File: rtl/edge_capture_chk.sv
module edge_capture_chk #(
  parameter int NCH = 4,
  parameter int TW  = 32,
  parameter int AW  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TW-1:0]     tmr_cnt,
  input logic              bus_we,
  input logic [AW-1:0]     bus_addr,
  input logic [TW-1:0]     bus_wdata,
  input logic [NCH*TW-1:0] cap_val,
  input logic [NCH-1:0]    cap_flag,
  input logic [NCH-1:0]    cap_ld,
  input logic [NCH-1:0]    irq_en,
  input logic [3*NCH-1:0]  ctrl
);
  for (genvar g = 0; g < NCH; g++) begin : g_p
    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ld[g] |=> cap_val[g*TW +: TW] == $past(tmr_cnt));
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_ld[g] |=> $stable(cap_val[g*TW +: TW]));
    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_ld[g] && irq_en[g]) |=> cap_flag[g]);
    p_flag_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_flag[g] && !(cap_ld[g] && irq_en[g])) |=> !cap_flag[g]);
    p_flag_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == AW'(1) && bus_wdata[g] && !(cap_ld[g] && irq_en[g]))
      |=> !cap_flag[g]);
  end

  p_ctrl_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(0)) |=> ctrl == $past(bus_wdata[3*NCH-1:0]));
endmodule

bind edge_capture edge_capture_chk #(.NCH(NCH), .TW(TW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cap_val(cap_val),
  .cap_flag(cap_flag), .cap_ld(cap_ld), .irq_en(irq_en), .ctrl(ctrl)
);

// File: tb/edge_capture_bench.sv
module edge_capture_bench;
  localparam int NCH = 4, TW = 32, AW = 4;

  logic clk = 0, rst_n = 0;
  logic [TW-1:0] tmr_cnt = '0;
  logic [NCH-1:0] cap_pin = '0;
  logic bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [TW-1:0] bus_wdata = '0;
  logic [TW-1:0] bus_rdata;
  logic [NCH*TW-1:0] cap_val;
  logic [NCH-1:0] cap_flag;

  int n_run = 0, n_fail = 0;
  logic [TW-1:0] m_cap [NCH];
  logic [NCH-1:0] m_flag = '0, lvl = '0;
  logic [3*NCH-1:0] m_ctrl = '0;

  always #4 clk = ~clk;

  edge_capture #(.NCH(NCH), .TW(TW), .AW(AW)) u_edge_capture (
    .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .cap_pin(cap_pin),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cap_val(cap_val), .cap_flag(cap_flag)
  );

  task automatic chk(string tag, logic [TW-1:0] act, logic [TW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [TW-1:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [TW-1:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  function automatic logic hit_of(int ch, logic old, logic v);
    return (v & !old & m_ctrl[3*ch]) | (!v & old & m_ctrl[3*ch+1]);
  endfunction

  task automatic ev(int ch, logic v);
    logic [TW-1:0] c;
    logic old, hit;
    old = lvl[ch];
    @(negedge clk); cap_pin[ch] = v; lvl[ch] = v; tmr_cnt = $urandom;
    @(negedge clk); tmr_cnt = $urandom;
    @(negedge clk);
    chk("R5 hold before third edge", cap_val[ch*TW +: TW], m_cap[ch]);
    c = $urandom; tmr_cnt = c;
    @(negedge clk);
    hit = hit_of(ch, old, v);
    if (hit) begin
      m_cap[ch] = c;
      if (m_ctrl[3*ch+2]) m_flag[ch] = 1'b1;
    end
    if (old == v || !hit) chk("R4 no capture", cap_val[ch*TW +: TW], m_cap[ch]);
    else if (v) chk("R2 rise capture", cap_val[ch*TW +: TW], m_cap[ch]);
    else chk("R3 fall capture", cap_val[ch*TW +: TW], m_cap[ch]);
    chk("R6 flags", TW'(cap_flag), TW'(m_flag));
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [TW-1:0] r, c, m;
    void'($urandom(32'd2024));
    for (int i = 0; i < NCH; i++) m_cap[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 cap_val zero", cap_val[TW-1:0] | cap_val[TW +: TW] | cap_val[2*TW +: TW] | cap_val[3*TW +: TW], '0);
    chk("R1 flags zero", TW'(cap_flag), '0);
    rd(0, r); chk("R1 ctrl zero", r, '0);

    m_ctrl = 12'h001; wr(0, TW'(m_ctrl));
    rd(0, r); chk("R11 ctrl readback", r, TW'(m_ctrl));
    ev(0, 1); ev(0, 0);

    m_ctrl = 12'h006; wr(0, TW'(m_ctrl));
    ev(0, 1); ev(0, 0);

    m_ctrl = 12'h7C0; wr(0, 32'hFFFF_F7C0);
    rd(0, r); chk("R11 ctrl width", r, TW'(m_ctrl));
    ev(2, 1); ev(2, 0); ev(3, 1);
    c = m_cap[2];
    ev(2, 1);
    chk("R10 overwrite unread", cap_val[2*TW +: TW] == c ? 32'd1 : 32'd0, 32'd0);

    wr(1, 32'h0000_0008); m_flag[3] = 1'b0;
    chk("R7 clear bit 3 only", TW'(cap_flag), TW'(m_flag));
    wr(1, 32'h0); chk("R7 zero write keeps", TW'(cap_flag), TW'(m_flag));

    r = cap_val[2*TW +: TW];
    wr(4, 32'hDEAD_BEEF);
    chk("R9 write ignored", cap_val[2*TW +: TW], r);
    rd(4, c); chk("R9 readback", c, r);

    m_ctrl = 12'h005; wr(0, TW'(m_ctrl));
    wr(1, 32'hF); m_flag = '0;
    @(negedge clk); cap_pin[0] = 1; lvl[0] = 1;
    @(negedge clk);
    @(negedge clk); bus_we = 1; bus_addr = 1; bus_wdata = 32'h1; tmr_cnt = 32'h1234_5678;
    @(negedge clk); bus_we = 0;
    m_cap[0] = 32'h1234_5678; m_flag[0] = 1'b1;
    chk("R8 set beats clear", TW'(cap_flag), TW'(m_flag));
    chk("R5 captured count", cap_val[TW-1:0], m_cap[0]);

    for (int k = 0; k < 120; k++) begin
      int ch;
      if (($urandom % 4) == 0) begin
        m_ctrl = 12'($urandom); wr(0, TW'(m_ctrl));
      end
      ch = int'($urandom % NCH);
      ev(ch, 1'($urandom));
      if (($urandom % 3) == 0) begin
        m = TW'($urandom % 16);
        wr(1, m); m_flag = m_flag & ~m[NCH-1:0];
        chk("R7 random clear", TW'(cap_flag), TW'(m_flag));
      end
      if (($urandom % 4) == 0) begin
        rd(AW'(ch + 2), r);
        chk("R9 bus read", r, m_cap[ch]);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule